// File: doc/BRIEF.md
# Sparse-to-Dense Sort Compaction Stage

This stage sits after a key-indexed sorting memory. In that memory every 8-bit code has been stored at the address equal to its 10-bit key, so reading the memory from address 0 upward yields the codes in ascending key order, with empty slots in between. An empty slot holds the all-zero code. The stage generates the scan addresses itself and issues one read per cycle. The memory answers one cycle later, so the stage delays each address by one cycle to pair it with the code it produced.

Every non-zero code is written, together with its key, into two dense memories at the next free position. A single write counter addresses both memories. Zero codes are dropped and do not advance the counter. When the scan has passed the top address, `done` rises and `entry_count` holds the number of packed pairs. A replay request then streams the pairs out in ascending key order, one per cycle. The stream stops at the packed count and flags the final pair.

Top module: `sort_compactor`

## Requirements
- R1: After reset, `done`, `out_valid`, `out_last` and `scan_rd` are 0 and `entry_count` is 0.
- R2: A `start` pulse, accepted when the stage is neither scanning nor replaying, makes `scan_rd` high for exactly 1024 consecutive cycles. `scan_addr` runs 0, 1, 2 … 1023 during those cycles, one step per cycle.
- R3: The scan address saturates: after the scan it stays at 1023 and `scan_rd` stays low until the next accepted `start`.
- R4: The code on `scan_code` in the cycle after a read is paired with the address of that read. Each replayed `out_key` equals the address whose read returned the replayed `out_code`.
- R5: A code of all zeros is discarded. `entry_count` after a scan equals the number of non-zero codes returned.
- R6: On `replay_req` while `done` is high and the count is non-zero, the pairs appear on consecutive cycles with `out_valid` high. They start with the lowest key, are in strictly ascending key order, and number exactly `entry_count`.
- R7: `out_last` is high together with the final replayed pair and at no other time.
- R8: `done` rises after the entry read at address 1023 has been processed and stays high until the next accepted `start`. An accepted `start` clears `done` and `entry_count` to 0 on the following cycle.
- R9: With a packed count of zero, `replay_req` produces no `out_valid`, and `done` stays high.
- R10: `scan_code` is ignored outside a scan. Values driven on it during a replay change neither the replayed pairs nor `entry_count`.
- R11: A scan in which all 1024 codes are non-zero gives `entry_count` = 1024. The replay of that scan has 1024 pairs, and `out_last` is on key 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new compaction scan; clears the count |
| replay_req | input | 1 | Stream out the packed pairs |
| scan_addr | output | 10 | Read address to the sparse sorting memory |
| scan_rd | output | 1 | Read strobe to the sparse sorting memory |
| scan_code | input | 8 | Code returned one cycle after each read |
| out_valid | output | 1 | Replayed pair is valid |
| out_code | output | 8 | Replayed code |
| out_key | output | 10 | Replayed key |
| out_last | output | 1 | Final replayed pair |
| done | output | 1 | Compaction finished |
| entry_count | output | 11 | Number of packed pairs (0 to 1024) |

## Verification
Some faults leave the count right but corrupt the replay. A write counter that advances on empty slots, or a key delay of the wrong depth, shows up in `entry_count` at `done` only in the first case. In the second, every replayed `out_key` is shifted by one against its code, and this is visible from the first replayed pair. A read pointer or last-entry compare that is off by one shows up in the same replay as a missing or extra pair, or as `out_last` on the wrong cycle. A scan address that wraps instead of saturating shows up on `scan_addr` and `scan_rd` in the cycle after the scan ends.

// File: rtl/sort_compactor_pkg.sv
package sort_compactor_pkg;
   typedef enum logic [1:0] {
      CMP_IDLE   = 2'd0,
      CMP_SCAN   = 2'd1,
      CMP_READY  = 2'd2,
      CMP_REPLAY = 2'd3
   } cmp_state_e;
endpackage

// File: rtl/cmp_scan_gen.sv
module cmp_scan_gen #(
   parameter int KEY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic [KEY_W-1:0] addr_o,
   output logic             rd_o,
   output logic [KEY_W-1:0] key_d_o,
   output logic             rd_d_o,
   output logic             last_d_o
);
   localparam logic [KEY_W-1:0] TOP_ADDR = {KEY_W{1'b1}};

   logic             active;
   logic [KEY_W-1:0] addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         addr     <= '0;
         key_d_o  <= '0;
         rd_d_o   <= 1'b0;
         last_d_o <= 1'b0;
      end else begin
         // one-cycle alignment with the sparse memory read latency
         rd_d_o   <= active;
         key_d_o  <= addr;
         last_d_o <= active && (addr == TOP_ADDR);
         if (start_i) begin
            active <= 1'b1;
            addr   <= '0;
         end else if (active) begin
            if (addr == TOP_ADDR) active <= 1'b0;   // saturate, no wrap
            else                  addr   <= addr + 1'b1;
         end
      end
   end

   assign addr_o = addr;
   assign rd_o   = active;

   // R2: address steps by one while a scan is running
   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_o && addr_o != TOP_ADDR && !start_i) |=> (addr_o == $past(addr_o) + 1'b1));
   // R3: idle address holds its value (saturated at the top after a scan)
   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_o && !start_i) |=> ($stable(addr_o) && !rd_o));
endmodule

// File: rtl/cmp_dense_ram.sv
module cmp_dense_ram #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [AW-1:0]    waddr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [AW-1:0]    raddr_i,
   output logic [WIDTH-1:0] rdata_o
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sort_compactor.sv
module sort_compactor
   import sort_compactor_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int KEY_W  = 10,
   localparam int DEPTH = 1 << KEY_W,
   localparam int CNT_W = KEY_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              replay_req,
   output logic [KEY_W-1:0]  scan_addr,
   output logic              scan_rd,
   input  logic [CODE_W-1:0] scan_code,
   output logic              out_valid,
   output logic [CODE_W-1:0] out_code,
   output logic [KEY_W-1:0]  out_key,
   output logic              out_last,
   output logic              done,
   output logic [CNT_W-1:0]  entry_count
);
   generate
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
      if (KEY_W < 1 || KEY_W > 16) begin : g_bad_key
         $error("KEY_W must lie in 1..16");
      end
   endgenerate

   cmp_state_e       state;
   logic [CNT_W-1:0] wr_cnt;
   logic [CNT_W-1:0] rd_ptr;
   logic             start_ok;
   logic             wr_en;
   logic [KEY_W-1:0] key_d;
   logic             rd_d;
   logic             last_d;
   logic [CODE_W-1:0] rd_code;
   logic [KEY_W-1:0]  rd_key;
   logic              rd_is_last;

   assign start_ok   = start && (state == CMP_IDLE || state == CMP_READY);
   assign wr_en      = (state == CMP_SCAN) && rd_d && (scan_code != '0);
   assign rd_is_last = (rd_ptr == wr_cnt - 1'b1);

   cmp_scan_gen #(.KEY_W(KEY_W)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_ok),
      .addr_o  (scan_addr),
      .rd_o    (scan_rd),
      .key_d_o (key_d),
      .rd_d_o  (rd_d),
      .last_d_o(last_d)
   );

   cmp_dense_ram #(.WIDTH(CODE_W), .DEPTH(DEPTH)) u_code_ram (
      .clk    (clk),
      .we_i   (wr_en),
      .waddr_i(wr_cnt[KEY_W-1:0]),
      .wdata_i(scan_code),
      .raddr_i(rd_ptr[KEY_W-1:0]),
      .rdata_o(rd_code)
   );

   cmp_dense_ram #(.WIDTH(KEY_W), .DEPTH(DEPTH)) u_key_ram (
      .clk    (clk),
      .we_i   (wr_en),
      .waddr_i(wr_cnt[KEY_W-1:0]),
      .wdata_i(key_d),
      .raddr_i(rd_ptr[KEY_W-1:0]),
      .rdata_o(rd_key)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CMP_IDLE;
         wr_cnt    <= '0;
         rd_ptr    <= '0;
         done      <= 1'b0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_code  <= '0;
         out_key   <= '0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         case (state)
            CMP_IDLE, CMP_READY: begin
               if (start_ok) begin
                  state  <= CMP_SCAN;
                  wr_cnt <= '0;
                  done   <= 1'b0;
               end else if (state == CMP_READY && replay_req && wr_cnt != '0) begin
                  state  <= CMP_REPLAY;
                  rd_ptr <= '0;
               end
            end
            CMP_SCAN: begin
               if (wr_en) wr_cnt <= wr_cnt + 1'b1;
               if (last_d) begin
                  state <= CMP_READY;
                  done  <= 1'b1;
               end
            end
            CMP_REPLAY: begin
               out_valid <= 1'b1;
               out_code  <= rd_code;
               out_key   <= rd_key;
               out_last  <= rd_is_last;
               rd_ptr    <= rd_ptr + 1'b1;
               if (rd_is_last) state <= CMP_READY;
            end
            default: state <= CMP_IDLE;
         endcase
      end
   end

   assign entry_count = wr_cnt;

   // R7: the last flag only rides on a valid pair
   a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
   // R9: nothing is replayed before compaction has finished
   a_r9_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> done);
   // R8: the count is frozen while done is held
   a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(entry_count));
   // R5: an empty slot never advances the count
   a_r5_zero_skipped: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CMP_SCAN && scan_code == '0) |=> $stable(entry_count));
   // R11: the count never exceeds the dense depth
   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      entry_count <= CNT_W'(DEPTH));
   // R10: outside a scan the count does not move unless a new scan starts
   a_r10_no_write_outside_scan: assert property (@(posedge clk) disable iff (!rst_n)
      (state != CMP_SCAN && !start_ok) |=> $stable(entry_count));
endmodule

// File: tb/sort_compactor_tb.sv
module sort_compactor_tb;
   localparam int KEY_W  = 10;
   localparam int CODE_W = 8;
   localparam int DEPTH  = 1 << KEY_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              replay_req = 1'b0;
   logic [KEY_W-1:0]  scan_addr;
   logic              scan_rd;
   logic [CODE_W-1:0] scan_code = '0;
   logic              out_valid;
   logic [CODE_W-1:0] out_code;
   logic [KEY_W-1:0]  out_key;
   logic              out_last;
   logic              done;
   logic [KEY_W:0]    entry_count;

   always #2 clk = ~clk;   // 250 MHz

   sort_compactor u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .replay_req(replay_req),
      .scan_addr(scan_addr), .scan_rd(scan_rd), .scan_code(scan_code),
      .out_valid(out_valid), .out_code(out_code), .out_key(out_key),
      .out_last(out_last), .done(done), .entry_count(entry_count)
   );

   // sparse source model: one cycle read latency
   logic [CODE_W-1:0] sparse [DEPTH];
   logic              inject = 1'b0;
   always @(posedge clk) begin
      if (inject)       scan_code <= 8'hA5;
      else if (scan_rd) scan_code <= sparse[scan_addr];
      else              scan_code <= '0;
   end

   // address order monitor
   int mon_next = 0;
   int mon_err  = 0;
   int mon_rd   = 0;
   always @(negedge clk) begin
      if (scan_rd) begin
         if (int'(scan_addr) != mon_next) mon_err++;
         mon_next = int'(scan_addr) + 1;
         mon_rd++;
      end
   end

   int vectors = 0;
   int miscompares = 0;
   int exp_key [DEPTH];
   int exp_n = 0;

   task automatic check(string req, string what, longint act, longint exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic fill(int stride, int phase, int salt);
      for (int k = 0; k < DEPTH; k++)
         sparse[k] = (k % stride == phase) ? 8'(k * salt + phase) : 8'h00;
   endtask

   task automatic build_expected();
      exp_n = 0;
      for (int k = 0; k < DEPTH; k++)
         if (sparse[k] != 0) begin
            exp_key[exp_n] = k;
            exp_n++;
         end
   endtask

   task automatic do_scan(string tag);
      int waited;
      mon_next = 0; mon_err = 0; mon_rd = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check("R8", {tag, " done cleared by start"}, done, 0);
      waited = 0;
      while (!done && waited < 1300) begin
         @(negedge clk);
         waited++;
      end
      check("R8", {tag, " done raised"}, done, 1);
      check("R2", {tag, " ascending addresses"}, mon_err, 0);
      check("R2", {tag, " read count"}, mon_rd, DEPTH);
      check("R3", {tag, " address saturated"}, scan_addr, DEPTH - 1);
      check("R3", {tag, " read strobe low"}, scan_rd, 0);
      check("R5", {tag, " packed count"}, entry_count, exp_n);
   endtask

   task automatic do_replay(string tag);
      int got = 0, bad_key = 0, bad_code = 0, bad_last = 0;
      @(negedge clk) replay_req = 1'b1;
      @(negedge clk) replay_req = 1'b0;
      for (int c = 0; c < exp_n + 6; c++) begin
         @(negedge clk);
         if (out_valid) begin
            if (got < exp_n) begin
               if (int'(out_key) != exp_key[got]) bad_key++;
               if (out_code != sparse[exp_key[got]]) bad_code++;
            end
            if (out_last != (got == exp_n - 1)) bad_last++;
            got++;
         end else if (out_last) bad_last++;
      end
      check("R6", {tag, " replay length"}, got, exp_n);
      check("R4", {tag, " key alignment"}, bad_key, 0);
      check("R6", {tag, " code order"}, bad_code, 0);
      check("R7", {tag, " last flag"}, bad_last, 0);
   endtask

   // stride, phase, salt
   localparam logic [23:0] PATS [5] = '{
      {8'd1,  8'd0,  8'd37},
      {8'd3,  8'd1,  8'd11},
      {8'd7,  8'd6,  8'd200},
      {8'd2,  8'd0,  8'd128},
      {8'd64, 8'd63, 8'd5}
   };

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "done after reset", done, 0);
      check("R1", "out_valid after reset", out_valid, 0);
      check("R1", "scan_rd after reset", scan_rd, 0);
      check("R1", "count after reset", entry_count, 0);

      foreach (PATS[i]) begin
         fill(int'(PATS[i][23:16]), int'(PATS[i][15:8]), int'(PATS[i][7:0]));
         build_expected();
         do_scan($sformatf("table%0d", i));
         do_replay($sformatf("table%0d", i));
      end

      // all empty: R9
      fill(1, 0, 0);
      build_expected();
      do_scan("empty");
      begin
         int seen = 0;
         @(negedge clk) replay_req = 1'b1;
         @(negedge clk) replay_req = 1'b0;
         for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (out_valid) seen++;
         end
         check("R9", "empty replay valid count", seen, 0);
         check("R9", "empty done held", done, 1);
      end

      // all occupied: R11
      for (int k = 0; k < DEPTH; k++) sparse[k] = 8'(k) | 8'h01;
      build_expected();
      do_scan("full");
      check("R11", "full count", entry_count, DEPTH);
      do_replay("full R11");

      // only the two end keys: R4 / R5
      fill(1, 0, 0);
      sparse[0] = 8'h3C;
      sparse[DEPTH-1] = 8'hC3;
      build_expected();
      do_scan("ends");
      do_replay("ends");

      // R10: garbage on scan_code during replay is ignored
      inject = 1'b1;
      do_replay("inject R10");
      inject = 1'b0;
      @(negedge clk);
      check("R10", "count after inject", entry_count, exp_n);
      do_replay("after inject R10");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule